// File: doc/BRIEF.md
# Serial ADC Readout Sequencer

This block reads one sample from a serial-output analog-to-digital converter for each start request. It drives the converter's select line and serial clock. It waits out the converter's fixed conversion latency, checks a leading zero bit, and then shifts in a 16-bit result word, most significant bit first. The serial clock is a divided copy of the system clock, and all frame timing is counted in serial-clock periods.

A frame has four parts, in this order:

1. Select is held high for one serial period.
2. Select falls together with a falling serial-clock edge. This edge is the reference for the rest of the frame.
3. Five falling edges later the converter drives a 0.
4. On the next sixteen falling edges the converter presents the data bits.

The converter changes its output on falling edges, and the sequencer samples on rising edges. One half period after the last sample, the serial clock returns low. At that point the sequencer pulses a valid strobe for one system clock with the assembled word, and drops busy in the same cycle.

The result interface is a plain one-cycle strobe and has no back-pressure. The consumer must take the word in the cycle the strobe is high. The word also stays on the output until the next strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, the next clock edge clears `busy_o`, `cs_o`, `sclk_o`, `sample_valid_o` and `err_o` to 0.
- R2: A high `start_i` in idle is accepted at a clock edge. From that edge `busy_o` is 1 and `cs_o` is 1 for exactly one serial period, which is 2*HALF_DIV system clocks.
- R3: `sclk_o` is low whenever `busy_o` is low. It has a period of 2*HALF_DIV system clocks, and each frame has exactly 23 rising edges. `cs_o` falls on the same clock edge as a falling `sclk_o` edge.
- R4: `sdata_i` is sampled on rising `sclk_o` edges. Counting rising edges after `cs_o` falls, the 6th rising edge samples the leading bit. The 7th through 22nd rising edges sample the data bits, most significant first.
- R5: `sample_valid_o` is high for exactly one cycle, 46*HALF_DIV clock edges after the edge that accepted `start_i`. `busy_o` falls in that same cycle, and `sample_o` then carries the word.
- R6: `err_o` is 1 after a frame whose leading bit read as 1, and 0 after a frame whose leading bit read as 0. It is cleared when the next start is accepted.
- R7: A `start_i` high while `busy_o` is 1 is ignored. No second frame follows, and the running frame returns its word unchanged.
- R8: `sample_o` holds the last delivered word until the next `sample_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request one conversion |
| busy_o | output | 1 | A frame is in progress |
| cs_o | output | 1 | Converter select pulse |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | 16 | Last assembled sample word |
| sample_valid_o | output | 1 | One-cycle strobe for a new word |
| err_o | output | 1 | Leading bit of the last frame was 1 |

## Verification
The assertions rely on three assumptions about the inputs:
- `rst` is high from time zero.
- `start_i` is synchronous to `clk`.
- The converter changes `sdata_i` only after a falling `sclk_o` edge, so the line is stable at every rising-edge sample.

The bench's converter model watches the outputs away from the clock edge and updates its data line only after it sees `sclk_o` fall. Random words and directed corners (all zeros, all ones, single set bits) are applied through that model. The bench also injects a stuck-high leading bit, a start request during a running frame, and a reset in the middle of a frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_WAIT,
    ST_LEAD,
    ST_DATA,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock divider: toggles every HALF system clocks while enabled.
module adc_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] half_cnt;
  logic          tick;

  assign tick   = en_i && (half_cnt == CW'(HALF - 1));
  assign rise_o = tick && !sclk_o;
  assign fall_o = tick && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      half_cnt <= '0;
      sclk_o   <= 1'b0;
    end else if (tick) begin
      half_cnt <= '0;
      sclk_o   <= ~sclk_o;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_in.sv
// MSB-first shift register with a held output copy.
module adc_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         load_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      word_o <= '0;
    end else begin
      if (shift_i) shreg <= {shreg[W-2:0], bit_i};
      if (load_i)  word_o <= shreg;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
// Frame sequencer, counting in serial-clock periods.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int LAT = 5,
  parameter int W   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic sdata_i,
  output logic cs_o,
  output logic busy_o,
  output logic clk_en_o,
  output logic shift_o,
  output logic load_o,
  output logic valid_o,
  output logic err_o
);
  localparam int MAXC = (LAT > W) ? LAT : W;
  localparam int CNTW = $clog2(MAXC + 1);

  seq_state_e      state;
  logic [CNTW-1:0] cnt;

  assign busy_o   = (state != ST_IDLE);
  assign clk_en_o = busy_o;
  assign shift_o  = (state == ST_DATA) && rise_i;
  assign load_o   = (state == ST_FINISH) && fall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cs_o    <= 1'b0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_SELECT;
          cs_o  <= 1'b1;
          err_o <= 1'b0;
        end
        ST_SELECT: if (fall_i) begin
          cs_o  <= 1'b0;
          cnt   <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: if (fall_i) begin
          if (cnt == CNTW'(LAT - 1)) begin
            cnt   <= '0;
            state <= ST_LEAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LEAD: if (rise_i) begin
          err_o <= sdata_i;
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_DATA: if (rise_i) begin
          if (cnt == CNTW'(W - 1)) state <= ST_FINISH;
          else cnt <= cnt + 1'b1;
        end
        ST_FINISH: if (fall_i) begin
          state   <= ST_IDLE;
          valid_o <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int HALF_DIV = 2,
  parameter int LATENCY  = 5,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  output logic                busy_o,
  output logic                cs_o,
  output logic                sclk_o,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                err_o
);
  logic clk_en, rise, fall, shift, load;

  adc_sclk_gen #(.HALF(HALF_DIV)) u_sclk (
    .clk(clk), .rst(rst), .en_i(clk_en),
    .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  adc_seq_fsm #(.LAT(LATENCY), .W(SAMPLE_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i),
    .rise_i(rise), .fall_i(fall), .sdata_i(sdata_i),
    .cs_o(cs_o), .busy_o(busy_o), .clk_en_o(clk_en),
    .shift_o(shift), .load_o(load), .valid_o(sample_valid_o), .err_o(err_o)
  );

  adc_shift_in #(.W(SAMPLE_W)) u_shift (
    .clk(clk), .rst(rst), .shift_i(shift), .bit_i(sdata_i),
    .load_i(load), .word_o(sample_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic cs_o,
  input logic sclk_o,
  input logic sample_valid_o,
  input logic err_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !cs_o && !sclk_o && !sample_valid_o && !err_o));

  // R2
  select_starts_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> $rose(busy_o));

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o);

  // R3
  select_falls_with_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_o) |-> $fell(sclk_o));

  // R5
  valid_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> ($fell(busy_o) && !cs_o));

  // R5
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |=> !sample_valid_o);

  // R7
  start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !sample_valid_o) |=> !$rose(cs_o));

  // R6
  err_cleared_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> !err_o);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .cs_o(cs_o),
  .sclk_o(sclk_o), .sample_valid_o(sample_valid_o), .err_o(err_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sdata = 1'b1;
  logic        busy, cs, sclk, valid, err;
  logic [15:0] sample;

  int errors = 0;
  int checks = 0;

  // converter model state
  logic [15:0] m_word = '0;
  logic        m_lead = 1'b0;
  logic        m_act = 1'b0;
  int          m_cnt = 0;
  logic        prev_cs = 1'b0, prev_sclk = 1'b0;
  int          rise_cnt = 0, cs_hi = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .cs_o(cs),
    .sclk_o(sclk), .sdata_i(sdata), .sample_o(sample),
    .sample_valid_o(valid), .err_o(err)
  );

  function automatic int exp_latency(int h);
    return 46 * h;
  endfunction

  function automatic int exp_select_width(int h);
    return 2 * h;
  endfunction

  // Converter stand-in: reacts to outputs between clock edges.
  always @(negedge clk) begin
    if (!prev_sclk && sclk) rise_cnt++;
    if (cs) cs_hi++;
    if (prev_cs && !cs) begin
      m_cnt = 0;
      m_act = 1'b1;
    end else if (m_act && prev_sclk && !sclk) begin
      m_cnt++;
      if (m_cnt == 5) sdata = m_lead;
      else if (m_cnt >= 6 && m_cnt <= 21) sdata = m_word[15-(m_cnt-6)];
      else if (m_cnt >= 22) begin
        sdata = 1'b1;
        m_act = 1'b0;
      end
    end
    prev_cs   = cs;
    prev_sclk = sclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(logic [15:0] w, logic lead, bit poke_start);
    int n;
    logic [15:0] held;
    m_word   = w;
    m_lead   = lead;
    rise_cnt = 0;
    cs_hi    = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'd1);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke_start) start = (n == 20 || n == 60);
    end while (!valid && n < 1000);
    start = 1'b0;
    chk("R5 latency", n, exp_latency(H));
    chk("R5 busy drops with valid", 32'(busy), 32'd0);
    if (!lead) chk("R4 sample word", 32'(sample), 32'(w));
    chk("R6 error flag", 32'(err), 32'(lead));
    chk("R3 sclk rises per frame", rise_cnt, 32'd23);
    chk("R2 select width", cs_hi, exp_select_width(H));
    held = sample;
    @(negedge clk);
    chk("R5 valid single cycle", 32'(valid), 32'd0);
    repeat (8) @(negedge clk);
    if (poke_start) chk("R7 no second frame", 32'(busy), 32'd0);
    chk("R8 sample held", 32'(sample), 32'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 cs after reset", 32'(cs), 32'd0);
    chk("R1 sclk after reset", 32'(sclk), 32'd0);
    chk("R1 valid after reset", 32'(valid), 32'd0);
    chk("R1 err after reset", 32'(err), 32'd0);

    // directed corners (R4)
    run_frame(16'h0000, 1'b0, 1'b0);
    run_frame(16'hFFFF, 1'b0, 1'b0);
    run_frame(16'h8000, 1'b0, 1'b0);
    run_frame(16'h0001, 1'b0, 1'b0);
    // R6: stuck leading bit, then a clean frame clears it
    run_frame(16'h1234, 1'b1, 1'b0);
    run_frame(16'hA5C3, 1'b0, 1'b0);
    // R7: start pulses during a running frame
    run_frame(16'h5A5A, 1'b0, 1'b1);
    // random words
    for (int i = 0; i < 20; i++) begin
      run_frame(16'($urandom), 1'b0, ($urandom % 4) == 0);
    end

    // R1: reset in the middle of a frame
    m_word = 16'hBEEF;
    m_lead = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst   = 1'b0;
    m_act = 1'b0;
    sdata = 1'b1;
    chk("R1 mid-frame reset busy", 32'(busy), 32'd0);
    chk("R1 mid-frame reset cs", 32'(cs), 32'd0);
    chk("R1 mid-frame reset sclk", 32'(sclk), 32'd0);
    chk("R1 mid-frame reset err", 32'(err), 32'd0);
    run_frame(16'h0F0F, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule